// File: doc/BRIEF.md
# I/O Register Space Decoder with Dual Address Views

This block is the I/O register space of a small processor core. It accepts one request per cycle and decodes it against a single register file that can be reached through two address views. The short view uses a 6-bit I/O number. The data-space view uses an 8-bit address in which the I/O number is shifted up by 0x20. The lowest 32 I/O numbers also accept single-bit operations: set, clear, test-for-set and test-for-clear. A test returns one flag, and the requester uses that flag to decide whether to skip. This block never changes program flow itself.

Local storage is small. There are three general-purpose byte registers, one extended byte register that only the data-space view can reach, and a status register. The status register holds four flags. Input strobes set these flags, and software clears a flag by writing a one to it. Two address windows are passed to a peripheral bus: data-space 0x20–0x2F and 0xC0–0xFF. On that bus, read data comes back in the same cycle. Any other address is reserved.

The request side is a valid/ready stream. `req_ready` is tied high, so the block never applies back-pressure. A request completes in the cycle in which `req_valid` is high. Its response (`rsp_*`) is valid in that same cycle, and a write takes effect at the next rising edge. To issue a second request, the requester keeps `req_valid` high for another cycle.

Top module: `iospace_decoder`

## Requirements
- R1: `req_op` uses this encoding: 0 short read, 1 short write, 2 data read, 3 data write, 4 bit set, 5 bit clear, 6 test-set, 7 test-clear. A short access to I/O number n and a data access to address n+0x20 reach the same register. The general registers sit at I/O 0x1E, 0x2A and 0x2B, and the status register sits at I/O 0x16.
- R2: Each of the following raises `rsp_err` in the same cycle and changes no register: a short read or write with an address above 0x3F, or a data access with an address below 0x20.
- R3: The extended register at data address 0x80 can be read and written by data accesses. A short access to 0x80 is an error.
- R4: Bit set and bit clear at an I/O number of 0x1F or below modify only the bit named by `req_bit`. On a general register, set gives 1 and clear gives 0.
- R5: A bit operation of any kind at an I/O number above 0x1F raises `rsp_err` and changes no register.
- R6: Test-set drives `rsp_flag` to the named bit's value. Test-clear drives it to the inverse of that value.
- R7: Status bits 3:0 are flags, and bits 7:4 always read zero. A rising `flag_set[i]` sets flag i. Writing the status register clears each flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged.
- R8: Bit set on the status register clears only the named flag. Bit clear on the status register has no effect. All other flags keep their state in both cases.
- R9: If `flag_set[i]` and a software clear of flag i fall in the same cycle, the flag ends up set.
- R10: A write to a reserved address changes nothing, and a read of a reserved address returns zero.
- R11: A request that hits a peripheral window drives `periph_valid`, `periph_write`, `periph_addr` (the data-space address) and `periph_wdata` in the same cycle. A read returns `periph_rdata`. A bit operation sends the modified byte.
- R12: Synchronous reset clears every register to zero. Reads respond combinationally, and writes take effect at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Always high; no back-pressure |
| req_op | input | 3 | Operation code (see R1) |
| req_addr | input | 8 | I/O number (short and bit ops) or data-space address |
| req_bit | input | 3 | Bit index for bit operations |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Read data for read operations, zero otherwise |
| rsp_flag | output | 1 | Skip flag from test operations |
| rsp_err | output | 1 | Address out of range for the operation |
| flag_set | input | 4 | Hardware set strobes for the status flags |
| periph_valid | output | 1 | Peripheral bus access this cycle |
| periph_write | output | 1 | Peripheral access is a write |
| periph_addr | output | 8 | Peripheral data-space address |
| periph_wdata | output | 8 | Peripheral write data |
| periph_rdata | input | 8 | Peripheral read data, same cycle |

## Verification
The bench checks the alias between the two views by writing through one view and reading back through the other. If the design dropped the 0x20 offset, the read-back would land on the wrong register. Bit operations aimed at the status register are the sharpest corner. A design that applied bit set as read-modify-write would write back ones over the other pending flags and clear them. A design that treated bit clear on a flag as a write would erase flags it should leave alone. The bench also drives a hardware set and a software clear of the same flag in one cycle, where a clear-priority design would lose the event. Finally, it sends requests to out-of-range and reserved addresses. There, a missing range check would either corrupt a register or leave `rsp_err` low.

// File: rtl/iosp_pkg.sv
package iosp_pkg;
  localparam int DW      = 8;
  localparam int AW      = 8;
  localparam int BW      = $clog2(DW);
  localparam int N_GP    = 3;
  localparam int N_FLAGS = 4;

  localparam logic [AW-1:0] IO_OFS      = 8'h20;
  localparam logic [AW-1:0] SHORT_MAX   = 8'h3F;
  localparam logic [AW-1:0] BIT_MAX     = 8'h1F;
  localparam logic [AW-1:0] STAT_DADDR  = 8'h36;
  localparam logic [AW-1:0] EXT_DADDR   = 8'h80;
  localparam logic [AW-1:0] PER_LO_END  = 8'h2F;
  localparam logic [AW-1:0] PER_HI_BASE = 8'hC0;

  localparam int SEL_EXT  = N_GP;
  localparam int SEL_STAT = N_GP + 1;
  localparam int SEL_PER  = N_GP + 2;
  localparam int N_SEL    = N_GP + 3;

  typedef enum logic [2:0] {
    OP_IN   = 3'd0,
    OP_OUT  = 3'd1,
    OP_LD   = 3'd2,
    OP_ST   = 3'd3,
    OP_BSET = 3'd4,
    OP_BCLR = 3'd5,
    OP_BTS  = 3'd6,
    OP_BTC  = 3'd7
  } op_e;

  function automatic logic [AW-1:0] gp_daddr(int idx);
    case (idx)
      0:       return 8'h3E;
      1:       return 8'h4A;
      default: return 8'h4B;
    endcase
  endfunction
endpackage

// File: rtl/iosp_decode.sv
module iosp_decode
  import iosp_pkg::*;
(
  input  op_e                 op,
  input  logic [AW-1:0]       addr,
  output logic                err,
  output logic                is_rd,
  output logic                is_wr,
  output logic                is_test,
  output logic [AW-1:0]       daddr,
  output logic [N_SEL-1:0]    sel
);
  logic short_view;
  logic bit_op;

  always_comb begin
    bit_op     = (op == OP_BSET) || (op == OP_BCLR) || (op == OP_BTS) || (op == OP_BTC);
    short_view = bit_op || (op == OP_IN) || (op == OP_OUT);
    daddr      = short_view ? (addr + IO_OFS) : addr;
    if (bit_op)          err = (addr > BIT_MAX);
    else if (short_view) err = (addr > SHORT_MAX);
    else                 err = (addr < IO_OFS);
    is_rd   = (op == OP_IN) || (op == OP_LD);
    is_wr   = (op == OP_OUT) || (op == OP_ST) || (op == OP_BSET) || (op == OP_BCLR);
    is_test = (op == OP_BTS) || (op == OP_BTC);
  end

  for (genvar g = 0; g < N_GP; g++) begin : g_gp_sel
    assign sel[g] = !err && (daddr == gp_daddr(g));
  end

  assign sel[SEL_EXT]  = !err && (daddr == EXT_DADDR);
  assign sel[SEL_STAT] = !err && (daddr == STAT_DADDR);
  assign sel[SEL_PER]  = !err && (((daddr >= IO_OFS) && (daddr <= PER_LO_END)) ||
                                  (daddr >= PER_HI_BASE));
endmodule

// File: rtl/iosp_bitops.sv
module iosp_bitops
  import iosp_pkg::*;
(
  input  op_e             op,
  input  logic [DW-1:0]   cur,
  input  logic [BW-1:0]   bitn,
  input  logic [DW-1:0]   wdata,
  input  logic            is_stat,
  output logic [DW-1:0]   new_val,
  output logic            test_flag
);
  logic [DW-1:0] mask;

  always_comb begin
    mask = DW'(1) << bitn;
    case (op)
      OP_BSET: new_val = is_stat ? mask : (cur | mask);
      OP_BCLR: new_val = is_stat ? '0   : (cur & ~mask);
      default: new_val = wdata;
    endcase
    test_flag = (op == OP_BTS) ? cur[bitn] : !cur[bitn];
  end
endmodule

// File: rtl/iosp_regs.sv
module iosp_regs
  import iosp_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [N_SEL-1:0]          wr_sel,
  input  logic [DW-1:0]             wr_data,
  input  logic [N_FLAGS-1:0]        flag_set,
  output logic [N_GP-1:0][DW-1:0]   gp_q,
  output logic [DW-1:0]             ext_q,
  output logic [DW-1:0]             stat_q
);
  logic [N_FLAGS-1:0] flags_q;
  logic [N_FLAGS-1:0] clr_mask;

  for (genvar g = 0; g < N_GP; g++) begin : g_gp
    always_ff @(posedge clk) begin
      if (rst)                    gp_q[g] <= '0;
      else if (wr_en && wr_sel[g]) gp_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                          ext_q <= '0;
    else if (wr_en && wr_sel[SEL_EXT]) ext_q <= wr_data;
  end

  assign clr_mask = (wr_en && wr_sel[SEL_STAT]) ? wr_data[N_FLAGS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= (flags_q & ~clr_mask) | flag_set;
  end

  assign stat_q = {{(DW-N_FLAGS){1'b0}}, flags_q};
endmodule

// File: rtl/iospace_decoder.sv
module iospace_decoder
  import iosp_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [2:0]         req_op,
  input  logic [AW-1:0]      req_addr,
  input  logic [BW-1:0]      req_bit,
  input  logic [DW-1:0]      req_wdata,
  output logic [DW-1:0]      rsp_rdata,
  output logic               rsp_flag,
  output logic               rsp_err,
  input  logic [N_FLAGS-1:0] flag_set,
  output logic               periph_valid,
  output logic               periph_write,
  output logic [AW-1:0]      periph_addr,
  output logic [DW-1:0]      periph_wdata,
  input  logic [DW-1:0]      periph_rdata
);
  op_e                   op;
  logic                  dec_err, is_rd, is_wr, is_test, test_flag;
  logic [AW-1:0]         daddr;
  logic [N_SEL-1:0]      sel;
  logic [DW-1:0]         cur, new_val;
  logic [N_GP-1:0][DW-1:0] gp_q;
  logic [DW-1:0]         ext_q, stat_q;
  logic                  wr_en;

  assign op = op_e'(req_op);

  iosp_decode u_decode (
    .op(op), .addr(req_addr), .err(dec_err), .is_rd(is_rd), .is_wr(is_wr),
    .is_test(is_test), .daddr(daddr), .sel(sel)
  );

  always_comb begin
    cur = '0;
    for (int i = 0; i < N_GP; i++) if (sel[i]) cur = gp_q[i];
    if (sel[SEL_EXT])  cur = ext_q;
    if (sel[SEL_STAT]) cur = stat_q;
    if (sel[SEL_PER])  cur = periph_rdata;
  end

  iosp_bitops u_bitops (
    .op(op), .cur(cur), .bitn(req_bit), .wdata(req_wdata),
    .is_stat(sel[SEL_STAT]), .new_val(new_val), .test_flag(test_flag)
  );

  assign wr_en = req_valid && is_wr && !dec_err && !sel[SEL_PER];

  iosp_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(sel), .wr_data(new_val),
    .flag_set(flag_set), .gp_q(gp_q), .ext_q(ext_q), .stat_q(stat_q)
  );

  assign req_ready    = 1'b1;
  assign rsp_err      = req_valid && dec_err;
  assign rsp_rdata    = (req_valid && is_rd) ? cur : '0;
  assign rsp_flag     = req_valid && is_test && !dec_err && test_flag;
  assign periph_valid = req_valid && sel[SEL_PER];
  assign periph_write = is_wr;
  assign periph_addr  = daddr;
  assign periph_wdata = new_val;
endmodule

// File: rtl/iosp_checker.sv
module iosp_checker
  import iosp_pkg::*;
(
  input logic                    clk,
  input logic                    rst,
  input logic                    req_valid,
  input logic [2:0]              req_op,
  input logic [AW-1:0]           req_addr,
  input logic                    rsp_err,
  input logic                    periph_valid,
  input logic [N_FLAGS-1:0]      flag_set,
  input logic [N_GP-1:0][DW-1:0] gp_q,
  input logic [DW-1:0]           ext_q,
  input logic [DW-1:0]           stat_q
);
  logic bit_req, short_req;
  assign bit_req   = req_op >= 3'd4;
  assign short_req = (req_op == 3'd0) || (req_op == 3'd1);

  AST_SHORT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && short_req && (req_addr > SHORT_MAX)) |-> rsp_err); // R2
  AST_BITOP_RANGE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && bit_req && (req_addr > BIT_MAX)) |-> rsp_err); // R5
  AST_ERR_NO_PERIPH: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> !periph_valid); // R2
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && rsp_err) |=> ($stable(gp_q) && $stable(ext_q))); // R2
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!req_valid && (flag_set == '0)) |=> $stable(stat_q)); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (flag_set != '0) |=> ((stat_q[N_FLAGS-1:0] & $past(flag_set)) == $past(flag_set))); // R9
endmodule

bind iospace_decoder iosp_checker u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
  .rsp_err(rsp_err), .periph_valid(periph_valid), .flag_set(flag_set),
  .gp_q(gp_q), .ext_q(ext_q), .stat_q(stat_q)
);

// File: tb/test_iospace_decoder.sv
`timescale 1ns/1ps
module test_iospace_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [2:0] req_op = '0;
  logic [7:0] req_addr = '0;
  logic [2:0] req_bit = '0;
  logic [7:0] req_wdata = '0;
  logic [7:0] rsp_rdata;
  logic       rsp_flag, rsp_err;
  logic [3:0] flag_set = '0;
  logic       periph_valid, periph_write;
  logic [7:0] periph_addr, periph_wdata;
  logic [7:0] periph_rdata = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [7:0] c_rdata, c_paddr, c_pwdata;
  logic       c_flag, c_err, c_pvalid, c_pwrite;

  always #2.5 clk = ~clk;

  iospace_decoder i_iospace_decoder (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_bit(req_bit), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_flag(rsp_flag), .rsp_err(rsp_err),
    .flag_set(flag_set), .periph_valid(periph_valid), .periph_write(periph_write),
    .periph_addr(periph_addr), .periph_wdata(periph_wdata), .periph_rdata(periph_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; response captured mid-cycle, returns at the next falling edge.
  task automatic do_req(input logic [2:0] op, input logic [7:0] a,
                        input logic [2:0] b, input logic [7:0] d);
    req_valid = 1'b1; req_op = op; req_addr = a; req_bit = b; req_wdata = d;
    #1;
    c_rdata = rsp_rdata; c_flag = rsp_flag; c_err = rsp_err;
    c_pvalid = periph_valid; c_pwrite = periph_write;
    c_paddr = periph_addr; c_pwdata = periph_wdata;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_req(3'd0, 8'h1E, 0, 0); chk("R12 gp0 after reset", c_rdata, 8'h00);
    do_req(3'd0, 8'h16, 0, 0); chk("R12 status after reset", c_rdata, 8'h00);
    do_req(3'd2, 8'h80, 0, 0); chk("R12 ext after reset", c_rdata, 8'h00);
  endtask

  task automatic t_alias();
    do_req(3'd1, 8'h2A, 0, 8'h5A);
    do_req(3'd2, 8'h4A, 0, 0);    chk("R1 short write, data read", c_rdata, 8'h5A);
    do_req(3'd3, 8'h4B, 0, 8'hC3);
    do_req(3'd0, 8'h2B, 0, 0);    chk("R1 data write, short read", c_rdata, 8'hC3);
    chk("R1 no error on valid access", c_err, 1'b0);
  endtask

  task automatic t_range();
    do_req(3'd1, 8'h6A, 0, 8'hFF); chk("R2 short write >0x3F errs", c_err, 1'b1);
    do_req(3'd2, 8'h10, 0, 0);     chk("R2 data read <0x20 errs", c_err, 1'b1);
    do_req(3'd0, 8'h2A, 0, 0);     chk("R2 gp1 unchanged by error", c_rdata, 8'h5A);
  endtask

  task automatic t_ext();
    do_req(3'd3, 8'h80, 0, 8'h77);
    do_req(3'd2, 8'h80, 0, 0); chk("R3 ext read back", c_rdata, 8'h77);
    do_req(3'd0, 8'h80, 0, 0); chk("R3 short access to ext errs", c_err, 1'b1);
  endtask

  task automatic t_bitops();
    do_req(3'd1, 8'h1E, 0, 8'h00);
    do_req(3'd4, 8'h1E, 3, 0);
    do_req(3'd4, 8'h1E, 7, 0);
    do_req(3'd0, 8'h1E, 0, 0); chk("R4 two bit sets", c_rdata, 8'h88);
    do_req(3'd5, 8'h1E, 3, 0);
    do_req(3'd0, 8'h1E, 0, 0); chk("R4 bit clear only named bit", c_rdata, 8'h80);
    do_req(3'd4, 8'h2A, 0, 0); chk("R5 bit set above 0x1F errs", c_err, 1'b1);
    do_req(3'd0, 8'h2A, 0, 0); chk("R5 gp1 unchanged", c_rdata, 8'h5A);
    do_req(3'd6, 8'h20, 0, 0); chk("R5 bit test above 0x1F errs", c_err, 1'b1);
  endtask

  task automatic t_test();
    do_req(3'd6, 8'h1E, 7, 0); chk("R6 test-set on 1", c_flag, 1'b1);
    do_req(3'd7, 8'h1E, 7, 0); chk("R6 test-clear on 1", c_flag, 1'b0);
    do_req(3'd6, 8'h1E, 0, 0); chk("R6 test-set on 0", c_flag, 1'b0);
    do_req(3'd7, 8'h1E, 0, 0); chk("R6 test-clear on 0", c_flag, 1'b1);
  endtask

  task automatic t_w1c();
    flag_set = 4'hF; @(posedge clk); @(negedge clk); flag_set = 4'h0;
    do_req(3'd0, 8'h16, 0, 0); chk("R7 flags set by strobes", c_rdata, 8'h0F);
    do_req(3'd1, 8'h16, 0, 8'hF5);
    do_req(3'd0, 8'h16, 0, 0); chk("R7 write-one clears, reserved read 0", c_rdata, 8'h0A);
  endtask

  task automatic t_bit_w1c();
    do_req(3'd4, 8'h16, 3, 0);
    do_req(3'd0, 8'h16, 0, 0); chk("R8 bit set clears only named flag", c_rdata, 8'h02);
    do_req(3'd5, 8'h16, 1, 0);
    do_req(3'd0, 8'h16, 0, 0); chk("R8 bit clear on status no effect", c_rdata, 8'h02);
  endtask

  task automatic t_race();
    flag_set = 4'h2;
    req_valid = 1'b1; req_op = 3'd1; req_addr = 8'h16; req_wdata = 8'h02;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; flag_set = 4'h0;
    do_req(3'd0, 8'h16, 0, 0); chk("R9 set beats clear", c_rdata, 8'h02);
  endtask

  task automatic t_reserved();
    do_req(3'd1, 8'h30, 0, 8'hFF);
    do_req(3'd0, 8'h30, 0, 0); chk("R10 reserved I/O reads zero", c_rdata, 8'h00);
    do_req(3'd3, 8'h90, 0, 8'hFF);
    do_req(3'd2, 8'h90, 0, 0); chk("R10 reserved ext reads zero", c_rdata, 8'h00);
    do_req(3'd0, 8'h2B, 0, 0); chk("R10 gp2 untouched", c_rdata, 8'hC3);
    do_req(3'd2, 8'h80, 0, 0); chk("R10 ext untouched", c_rdata, 8'h77);
  endtask

  task automatic t_periph();
    periph_rdata = 8'hA5;
    do_req(3'd0, 8'h05, 0, 0);
    chk("R11 periph read data", c_rdata, 8'hA5);
    chk("R11 periph valid", c_pvalid, 1'b1);
    chk("R11 periph addr", c_paddr, 8'h25);
    chk("R11 periph read not write", c_pwrite, 1'b0);
    do_req(3'd1, 8'h05, 0, 8'h3C);
    chk("R11 periph write strobe", c_pwrite, 1'b1);
    chk("R11 periph write data", c_pwdata, 8'h3C);
    do_req(3'd4, 8'h05, 1, 0);
    chk("R11 periph bit set data", c_pwdata, 8'hA7);
    do_req(3'd2, 8'hC4, 0, 0);
    chk("R11 periph high window addr", c_paddr, 8'hC4);
    do_req(3'd0, 8'h1E, 0, 0);
    chk("R11 no periph for local reg", c_pvalid, 1'b0);
  endtask

  task automatic t_midreset();
    rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
    do_req(3'd0, 8'h2A, 0, 0); chk("R12 reset clears gp1", c_rdata, 8'h00);
    do_req(3'd0, 8'h16, 0, 0); chk("R12 reset clears status", c_rdata, 8'h00);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_alias();
    t_range();
    t_ext();
    t_bitops();
    t_test();
    t_w1c();
    t_bit_w1c();
    t_race();
    t_reserved();
    t_periph();
    t_midreset();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule